// File: doc/BRIEF.md
# Dual-Clock Width-Converting FIFO

This block moves data between two unrelated clock domains. Its write port runs on one clock and its read port on the other, and each side takes its own data width. The two widths differ by a power of two. When the write side is the narrower one, consecutive writes are gathered into one wide read word, and the first word written fills the least significant slot. When the read side is the narrower one, each wide write word is handed out in slices, lowest slice first.

Each domain has its own flags and fill count. Full on the write side and empty on the read side decide whether a request is accepted. The opposite-domain copies, read-side full and write-side empty, only follow those flags. Each domain's view of the other pointer comes through a Gray-coded, two-stage synchronizer, so these copies settle two to three destination clocks after the change. Both domains also report almost-full and almost-empty against compile-time levels that are counted in that domain's own word size. The depth is given in write-width words.

The read data is registered. A read accepted on a rising read clock edge presents its word on `rd_data` after that edge. Each domain has a synchronous, active-high reset. Assert both resets together.

Top module: `xclk_fifo`

## Requirements
- R1: With WR_W narrower than RD_W, the first write-width word written after the read point lands in bits [WR_W-1:0] of the next read word, and later writes fill higher slots in order.
- R2: With WR_W wider than RD_W, the read port returns the slices of each write word lowest slice first: bits [RD_W-1:0] come first.
- R3: A write request while `wr_full` is high is ignored. The count does not rise, and the stored data read back later is unchanged.
- R4: A read request while `rd_empty` is high is ignored. `rd_data` holds its value, and the next word read after new data arrives is the correct one.
- R5: `wr_used` counts stored data in write words, and a write word that has been only partly read still counts as stored. `wr_full` is high exactly when DEPTH write words are counted, and stored data never exceeds the capacity.
- R6: `rd_used` counts complete read words available, and `rd_empty` is high exactly when that count is zero.
- R7: `rd_full` and `wr_empty` mirror the far domain's condition with a lag. They do not change in the first destination clock edge after the far pointer moves, and they settle within three destination clocks.
- R8: Each domain's almost-full output is high when its count is greater than or equal to that domain's almost-full level (`WR_AFULL` in write words, `RD_AFULL` in read words).
- R9: Each domain's almost-empty output is high when its count is strictly below that domain's almost-empty level (`WR_AEMPTY`, `RD_AEMPTY`).
- R10: After reset, both sides report empty, not full, a count of zero, and almost-empty.
- R11: Pointers pass between domains in Gray code that changes at most one bit per source clock. Data order is kept across pointer wrap-around.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| wr_clk | input | 1 | Write-domain clock |
| wr_rst | input | 1 | Write-domain synchronous reset, active high |
| wr_req | input | 1 | Write request; accepted when `wr_full` is low |
| wr_data | input | WR_W | Write data |
| wr_full | output | 1 | Write-domain full (decides acceptance) |
| wr_empty | output | 1 | Write-domain lagging copy of empty |
| wr_used | output | clog2(DEPTH)+1 | Stored write words, seen from the write domain |
| wr_afull | output | 1 | `wr_used` >= WR_AFULL |
| wr_aempty | output | 1 | `wr_used` < WR_AEMPTY |
| rd_clk | input | 1 | Read-domain clock |
| rd_rst | input | 1 | Read-domain synchronous reset, active high |
| rd_req | input | 1 | Read request; accepted when `rd_empty` is low |
| rd_data | output | RD_W | Registered read data |
| rd_full | output | 1 | Read-domain lagging copy of full |
| rd_empty | output | 1 | Read-domain empty (decides acceptance) |
| rd_used | output | clog2(DEPTH*WR_W/RD_W)+1 | Complete read words, seen from the read domain |
| rd_afull | output | 1 | `rd_used` >= RD_AFULL |
| rd_aempty | output | 1 | `rd_used` < RD_AEMPTY |

## Verification
Some properties hold on every clock and are checked every cycle in both domains. These are: stored data never exceeds the capacity; full and empty are never high together; a refused request leaves the pointer unchanged; the outgoing Gray pointer moves by at most one bit; and full and a zero count imply their almost flags. What only the directed scenarios can show is the data itself. This covers the slot order of packing and unpacking, the values around the threshold edges, the two-edge lag of the far-domain copies, the partly-read word that still counts as stored, and the order of data once the pointers wrap.

// File: rtl/xfifo_pkg.sv
`timescale 1ns/1ps
package xfifo_pkg;

    // Which clock domain a pointer side belongs to.
    typedef enum logic {
        SIDE_WR = 1'b0,
        SIDE_RD = 1'b1
    } side_e;

    // Smaller of two widths: the granule the storage is organised in.
    function automatic int narrow_of(input int a, input int b);
        return (a < b) ? a : b;
    endfunction

endpackage

// File: rtl/xfifo_sync.sv
`timescale 1ns/1ps
// Two-stage synchronizer for a Gray-coded pointer vector.
module xfifo_sync #(
    parameter int W = 4
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] stage1_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            stage1_q <= '0;
            q        <= '0;
        end else begin
            stage1_q <= d;
            q        <= stage1_q;
        end
    end
endmodule

// File: rtl/xfifo_store.sv
`timescale 1ns/1ps
// Storage organised in narrow granules; a write fills WK granules, a read takes RK.
module xfifo_store #(
    parameter int N  = 8,
    parameter int AN = 4,
    parameter int WK = 1,
    parameter int RK = 4
) (
    input  logic            wclk,
    input  logic            we,
    input  logic [AN-1:0]   waddr,
    input  logic [WK*N-1:0] wdata,
    input  logic            rclk,
    input  logic            rrst,
    input  logic            re,
    input  logic [AN-1:0]   raddr,
    output logic [RK*N-1:0] rdata
);
    localparam int ENTRIES = 1 << AN;

    logic [N-1:0] mem [ENTRIES];

    // Slot k of the write word goes to granule waddr+k (lowest slot first).
    always_ff @(posedge wclk) begin
        if (we) begin
            for (int k = 0; k < WK; k++) begin
                mem[waddr + AN'(k)] <= wdata[k*N +: N];
            end
        end
    end

    always_ff @(posedge rclk) begin
        if (rrst) begin
            rdata <= '0;
        end else if (re) begin
            for (int k = 0; k < RK; k++) begin
                rdata[k*N +: N] <= mem[raddr + AN'(k)];
            end
        end
    end
endmodule

// File: rtl/xfifo_side.sv
`timescale 1ns/1ps
// One domain's pointer, Gray export and flag/count logic.
module xfifo_side
    import xfifo_pkg::*;
#(
    parameter int    AN      = 4,   // log2 of capacity in narrow granules
    parameter int    OWN_SH  = 0,   // log2 granules per own-side word
    parameter int    FAR_SH  = 2,   // log2 granules per far-side word
    parameter int    WSH     = 0,   // log2 granules per write word
    parameter int    RSH     = 2,   // log2 granules per read word
    parameter side_e SIDE    = SIDE_WR,
    parameter int    AF_LVL  = 12,
    parameter int    AE_LVL  = 4
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 req,
    input  logic [AN-FAR_SH:0]   far_gray,
    output logic [AN-OWN_SH:0]   ptr_gray,
    output logic [AN-1:0]        addr,
    output logic                 accept,
    output logic                 full,
    output logic                 empty,
    output logic [AN-OWN_SH:0]   used,
    output logic                 afull,
    output logic                 aempty
);
    localparam int OW = AN - OWN_SH;
    localparam int FW = AN - FAR_SH;
    localparam logic [AN:0] CAP        = (AN+1)'(1 << AN);
    localparam logic [AN:0] FULL_AT    = (AN+1)'((1 << AN) - (1 << WSH) + 1);
    localparam logic [AN:0] EMPTY_BELOW = (AN+1)'(1 << RSH);
    localparam logic [AN:0] ROUND_UP   = (AN+1)'((1 << WSH) - 1);

    logic [OW:0] ptr_q;
    logic [OW:0] ptr_nx;
    logic [OW:0] gray_q;
    logic [FW:0] far_bin;
    logic [AN:0] own_n;
    logic [AN:0] far_n;
    logic [AN:0] fill_n;
    logic [AN:0] up_n;

    // Gray to binary for the synchronized far pointer.
    always_comb begin
        for (int i = 0; i <= FW; i++) begin
            far_bin[i] = ^(far_gray >> i);
        end
    end

    // Both pointers expressed in narrow granules.
    always_comb begin
        own_n = '0;
        own_n[AN:OWN_SH] = ptr_q;
        far_n = '0;
        far_n[AN:FAR_SH] = far_bin;
    end

    always_comb begin
        fill_n = (SIDE == SIDE_WR) ? (own_n - far_n) : (far_n - own_n);
        up_n   = fill_n + ROUND_UP;
    end

    // Write side rounds a partly read word up; read side counts whole words.
    always_comb begin
        used   = (SIDE == SIDE_WR) ? up_n[AN:OWN_SH] : fill_n[AN:OWN_SH];
        full   = (fill_n >= FULL_AT);
        empty  = (fill_n < EMPTY_BELOW);
        afull  = (used >= (OW+1)'(AF_LVL));
        aempty = (used < (OW+1)'(AE_LVL));
        accept = req && ((SIDE == SIDE_WR) ? !full : !empty);
        ptr_nx = accept ? (ptr_q + 1'b1) : ptr_q;
        addr   = own_n[AN-1:0];
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ptr_q  <= '0;
            gray_q <= '0;
        end else begin
            ptr_q  <= ptr_nx;
            gray_q <= ptr_nx ^ (ptr_nx >> 1);
        end
    end

    assign ptr_gray = gray_q;

    // R5
    no_overflow_chk: assert property (@(posedge clk) disable iff (rst)
        fill_n <= CAP);

    // R5
    full_excl_empty_chk: assert property (@(posedge clk) disable iff (rst)
        full |-> !empty);

    // R3 on the write side, R4 on the read side
    ignored_req_chk: assert property (@(posedge clk) disable iff (rst)
        (req && ((SIDE == SIDE_WR) ? full : empty)) |=> $stable(ptr_q));

    // R11
    gray_step_chk: assert property (@(posedge clk) disable iff (rst)
        $countones(gray_q ^ $past(gray_q)) <= 1);

    generate
        if (AF_LVL <= (1 << OW)) begin : g_af_chk
            // R8
            full_implies_afull_chk: assert property (@(posedge clk) disable iff (rst)
                (used == (OW+1)'(1 << OW)) |-> afull);
        end
        if (AE_LVL >= 1) begin : g_ae_chk
            // R9
            zero_implies_aempty_chk: assert property (@(posedge clk) disable iff (rst)
                (used == '0) |-> aempty);
        end
    endgenerate
endmodule

// File: rtl/xclk_fifo.sv
`timescale 1ns/1ps
module xclk_fifo
    import xfifo_pkg::*;
#(
    parameter int WR_W      = 8,
    parameter int RD_W      = 32,
    parameter int DEPTH     = 16,
    parameter int WR_AFULL  = 12,
    parameter int WR_AEMPTY = 4,
    parameter int RD_AFULL  = 3,
    parameter int RD_AEMPTY = 1
) (
    input  logic                                 wr_clk,
    input  logic                                 wr_rst,
    input  logic                                 wr_req,
    input  logic [WR_W-1:0]                      wr_data,
    output logic                                 wr_full,
    output logic                                 wr_empty,
    output logic [$clog2(DEPTH):0]               wr_used,
    output logic                                 wr_afull,
    output logic                                 wr_aempty,
    input  logic                                 rd_clk,
    input  logic                                 rd_rst,
    input  logic                                 rd_req,
    output logic [RD_W-1:0]                      rd_data,
    output logic                                 rd_full,
    output logic                                 rd_empty,
    output logic [$clog2(DEPTH*WR_W/RD_W):0]     rd_used,
    output logic                                 rd_afull,
    output logic                                 rd_aempty
);
    localparam int N   = narrow_of(WR_W, RD_W);
    localparam int WSH = $clog2(WR_W / N);
    localparam int RSH = $clog2(RD_W / N);
    localparam int AN  = $clog2(DEPTH) + WSH;
    localparam int WGW = AN - WSH + 1;
    localparam int RGW = AN - RSH + 1;

    logic [WGW-1:0] wgray;
    logic [WGW-1:0] wgray_in_rd;
    logic [RGW-1:0] rgray;
    logic [RGW-1:0] rgray_in_wr;
    logic [AN-1:0]  waddr;
    logic [AN-1:0]  raddr;
    logic           wacc;
    logic           racc;

    xfifo_side #(
        .AN(AN), .OWN_SH(WSH), .FAR_SH(RSH), .WSH(WSH), .RSH(RSH),
        .SIDE(SIDE_WR), .AF_LVL(WR_AFULL), .AE_LVL(WR_AEMPTY)
    ) u_wside (
        .clk(wr_clk), .rst(wr_rst), .req(wr_req),
        .far_gray(rgray_in_wr), .ptr_gray(wgray), .addr(waddr), .accept(wacc),
        .full(wr_full), .empty(wr_empty), .used(wr_used),
        .afull(wr_afull), .aempty(wr_aempty)
    );

    xfifo_side #(
        .AN(AN), .OWN_SH(RSH), .FAR_SH(WSH), .WSH(WSH), .RSH(RSH),
        .SIDE(SIDE_RD), .AF_LVL(RD_AFULL), .AE_LVL(RD_AEMPTY)
    ) u_rside (
        .clk(rd_clk), .rst(rd_rst), .req(rd_req),
        .far_gray(wgray_in_rd), .ptr_gray(rgray), .addr(raddr), .accept(racc),
        .full(rd_full), .empty(rd_empty), .used(rd_used),
        .afull(rd_afull), .aempty(rd_aempty)
    );

    xfifo_sync #(.W(WGW)) u_w2r (
        .clk(rd_clk), .rst(rd_rst), .d(wgray), .q(wgray_in_rd)
    );

    xfifo_sync #(.W(RGW)) u_r2w (
        .clk(wr_clk), .rst(wr_rst), .d(rgray), .q(rgray_in_wr)
    );

    xfifo_store #(
        .N(N), .AN(AN), .WK(1 << WSH), .RK(1 << RSH)
    ) u_store (
        .wclk(wr_clk), .we(wacc), .waddr(waddr), .wdata(wr_data),
        .rclk(rd_clk), .rrst(rd_rst), .re(racc), .raddr(raddr), .rdata(rd_data)
    );
endmodule

// File: tb/xclk_fifo_test.sv
`timescale 1ns/1ps
module xclk_fifo_test;
    logic wr_clk = 1'b0;
    logic rd_clk = 1'b0;
    logic wr_rst = 1'b1;
    logic rd_rst = 1'b1;
    always #2 wr_clk = ~wr_clk;   // 250 MHz
    always #3 rd_clk = ~rd_clk;

    int checks = 0;
    int errors = 0;

    // Instance A: 8-bit writes packed into 32-bit reads, 16 write words deep.
    logic        a_wreq = 1'b0, a_rreq = 1'b0;
    logic [7:0]  a_wdata = '0;
    logic        a_wfull, a_wempty, a_wafull, a_waempty;
    logic [4:0]  a_wused;
    logic [31:0] a_rdata;
    logic        a_rfull, a_rempty, a_rafull, a_raempty;
    logic [2:0]  a_rused;

    xclk_fifo #(.WR_W(8), .RD_W(32), .DEPTH(16), .WR_AFULL(12), .WR_AEMPTY(4),
                .RD_AFULL(3), .RD_AEMPTY(1)) uut (
        .wr_clk(wr_clk), .wr_rst(wr_rst), .wr_req(a_wreq), .wr_data(a_wdata),
        .wr_full(a_wfull), .wr_empty(a_wempty), .wr_used(a_wused),
        .wr_afull(a_wafull), .wr_aempty(a_waempty),
        .rd_clk(rd_clk), .rd_rst(rd_rst), .rd_req(a_rreq), .rd_data(a_rdata),
        .rd_full(a_rfull), .rd_empty(a_rempty), .rd_used(a_rused),
        .rd_afull(a_rafull), .rd_aempty(a_raempty)
    );

    // Instance B: 32-bit writes unpacked into 8-bit reads, 4 write words deep.
    logic        b_wreq = 1'b0, b_rreq = 1'b0;
    logic [31:0] b_wdata = '0;
    logic        b_wfull, b_wempty, b_wafull, b_waempty;
    logic [2:0]  b_wused;
    logic [7:0]  b_rdata;
    logic        b_rfull, b_rempty, b_rafull, b_raempty;
    logic [4:0]  b_rused;

    xclk_fifo #(.WR_W(32), .RD_W(8), .DEPTH(4), .WR_AFULL(3), .WR_AEMPTY(1),
                .RD_AFULL(12), .RD_AEMPTY(4)) uut_b (
        .wr_clk(wr_clk), .wr_rst(wr_rst), .wr_req(b_wreq), .wr_data(b_wdata),
        .wr_full(b_wfull), .wr_empty(b_wempty), .wr_used(b_wused),
        .wr_afull(b_wafull), .wr_aempty(b_waempty),
        .rd_clk(rd_clk), .rd_rst(rd_rst), .rd_req(b_rreq), .rd_data(b_rdata),
        .rd_full(b_rfull), .rd_empty(b_rempty), .rd_used(b_rused),
        .rd_afull(b_rafull), .rd_aempty(b_raempty)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic wr_a(input logic [7:0] v);
        @(negedge wr_clk); a_wreq = 1'b1; a_wdata = v;
        @(negedge wr_clk); a_wreq = 1'b0;
    endtask

    task automatic rd_a(output logic [31:0] v);
        @(negedge rd_clk); a_rreq = 1'b1;
        @(negedge rd_clk); a_rreq = 1'b0; v = a_rdata;
    endtask

    task automatic wr_b(input logic [31:0] v);
        @(negedge wr_clk); b_wreq = 1'b1; b_wdata = v;
        @(negedge wr_clk); b_wreq = 1'b0;
    endtask

    task automatic rd_b(output logic [7:0] v);
        @(negedge rd_clk); b_rreq = 1'b1;
        @(negedge rd_clk); b_rreq = 1'b0; v = b_rdata;
    endtask

    task automatic settle();
        repeat (6) @(negedge rd_clk);
        repeat (6) @(negedge wr_clk);
    endtask

    task automatic t_reset();
        chk("R10 a wr_empty", 32'(a_wempty), 1);
        chk("R10 a rd_empty", 32'(a_rempty), 1);
        chk("R10 a wr_used", 32'(a_wused), 0);
        chk("R10 a rd_used", 32'(a_rused), 0);
        chk("R10 a wr_full", 32'(a_wfull), 0);
        chk("R10 a rd_full", 32'(a_rfull), 0);
        chk("R10 a aempty both", {30'd0, a_waempty, a_raempty}, 32'h3);
        chk("R10 b flags", {28'd0, b_wempty, b_rempty, b_wfull, b_rfull}, 32'hC);
    endtask

    task automatic t_pack();
        logic [31:0] w;
        wr_a(8'h11); wr_a(8'h22); wr_a(8'h33);
        settle();
        chk("R6 partial word not readable", 32'(a_rempty), 1);
        chk("R6 rd_used partial", 32'(a_rused), 0);
        chk("R5 wr_used three", 32'(a_wused), 3);
        wr_a(8'h44);
        settle();
        chk("R6 rd_used one", 32'(a_rused), 1);
        rd_a(w);
        chk("R1 packed order", w, 32'h44332211);
        settle();
        chk("R7 wr_empty follows", 32'(a_wempty), 1);
        chk("R5 wr_used drained", 32'(a_wused), 0);
    endtask

    task automatic t_thresh();
        logic [31:0] w;
        for (int i = 0; i < 3; i++) wr_a(8'(8'h40 + i));
        settle();
        chk("R9 wr_aempty below level", 32'(a_waempty), 1);
        wr_a(8'h43);
        settle();
        chk("R9 wr_aempty at level", 32'(a_waempty), 0);
        chk("R9 rd_aempty one word", 32'(a_raempty), 0);
        for (int i = 4; i < 11; i++) wr_a(8'(8'h40 + i));
        chk("R8 wr_afull at 11", 32'(a_wafull), 0);
        wr_a(8'h4B);
        chk("R8 wr_afull at 12", 32'(a_wafull), 1);
        settle();
        chk("R8 rd_afull at 3", 32'(a_rafull), 1);
        for (int j = 0; j < 3; j++) begin
            rd_a(w);
            chk("R1 drain word", w, {8'(8'h43 + 4*j), 8'(8'h42 + 4*j), 8'(8'h41 + 4*j), 8'(8'h40 + 4*j)});
        end
        settle();
        chk("R8 rd_afull drained", 32'(a_rafull), 0);
    endtask

    task automatic t_full();
        logic [31:0] w;
        for (int i = 0; i < 15; i++) wr_a(8'(8'h80 + i));
        chk("R5 not full at 15", 32'(a_wfull), 0);
        wr_a(8'h8F);
        chk("R5 full at depth", 32'(a_wfull), 1);
        chk("R5 wr_used depth", 32'(a_wused), 16);
        wr_a(8'hFF);
        settle();
        chk("R3 count unchanged", 32'(a_wused), 16);
        chk("R7 rd_full follows", 32'(a_rfull), 1);
        chk("R6 rd_used full", 32'(a_rused), 4);
        for (int j = 0; j < 4; j++) begin
            rd_a(w);
            chk("R3 R11 data after wrap", w, {8'(8'h83 + 4*j), 8'(8'h82 + 4*j), 8'(8'h81 + 4*j), 8'(8'h80 + 4*j)});
        end
        settle();
        chk("R7 rd_full cleared", 32'(a_rfull), 0);
    endtask

    task automatic t_empty_read();
        logic [31:0] w;
        rd_a(w);
        chk("R4 rd_data held", w, 32'h8F8E8D8C);
        chk("R4 rd_used zero", 32'(a_rused), 0);
        wr_a(8'h01); wr_a(8'h02); wr_a(8'h03); wr_a(8'h04);
        settle();
        rd_a(w);
        chk("R4 next word correct", w, 32'h04030201);
        settle();
    endtask

    task automatic t_lag();
        @(negedge wr_clk); b_wreq = 1'b1; b_wdata = 32'hA1B2C3D4;
        @(posedge wr_clk);
        @(negedge wr_clk); b_wreq = 1'b0;
        // Accepted at the edge above; far view may have taken at most one sample.
        chk("R5 wr_used immediate", 32'(b_wused), 1);
        @(posedge rd_clk); #1;
        chk("R7 rd_empty lags", 32'(b_rempty), 1);
        repeat (3) @(negedge rd_clk);
        chk("R6 rd_empty settled", 32'(b_rempty), 0);
        chk("R6 rd_used four", 32'(b_rused), 4);
    endtask

    task automatic t_unpack();
        logic [7:0] v;
        rd_b(v);
        chk("R2 slice 0", 32'(v), 32'hD4);
        settle();
        chk("R5 partly read word counts", 32'(b_wused), 1);
        rd_b(v); chk("R2 slice 1", 32'(v), 32'hC3);
        rd_b(v); chk("R2 slice 2", 32'(v), 32'hB2);
        rd_b(v); chk("R2 slice 3", 32'(v), 32'hA1);
        settle();
        chk("R7 b wr_empty", 32'(b_wempty), 1);
        chk("R5 b wr_used zero", 32'(b_wused), 0);
    endtask

    task automatic t_b_full();
        logic [7:0] v;
        for (int i = 0; i < 4; i++) wr_b({8'(4*i+3), 8'(4*i+2), 8'(4*i+1), 8'(4*i)});
        chk("R5 b full", 32'(b_wfull), 1);
        chk("R8 b wr_afull", 32'(b_wafull), 1);
        wr_b(32'hDEADBEEF);
        settle();
        chk("R8 b rd_afull", 32'(b_rafull), 1);
        chk("R7 b rd_full", 32'(b_rfull), 1);
        for (int k = 0; k < 16; k++) begin
            rd_b(v);
            chk("R2 R3 R11 b stream", 32'(v), 32'(k));
        end
        settle();
        chk("R9 b rd_aempty", 32'(b_raempty), 1);
    endtask

    initial begin
        repeat (10) @(negedge wr_clk);
        wr_rst = 1'b0;
        rd_rst = 1'b0;
        repeat (4) @(negedge rd_clk);
        t_reset();
        t_pack();
        t_thresh();
        t_full();
        t_empty_read();
        t_lag();
        t_unpack();
        t_b_full();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        #800000;
        errors++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule